// File: doc/BRIEF.md
# Sync-Locked Timing Start Generator

This block locks an internal video timing generator to external horizontal and vertical sync inputs. Both sync inputs pass through a two-flop synchroniser and are acted on at their rising edges. After a vertical edge, the block waits a programmed number of horizontal edges, then a programmed number of clocks. It then emits a single-cycle start pulse that the timing generator uses to clear its pixel and line counters. Either delay may exceed the length of a line or a frame. The start then lands in a later line or frame.

The block also measures the input line period in clocks. It classifies the incoming video as interlaced or progressive from where each vertical edge falls within the line. Typical settings are a horizontal delay of 61 clocks and a vertical delay of 3 lines.

Top module: `sync_start_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `start_pulse` is 0, `line_period` is 0 and `interlace` is 0.
- R2: The sync inputs are acted on only at their rising edges, after a two-flop synchroniser. A raw edge first seen high at clock edge k is acted on at clock edge k+2. `start_pulse` is never high for two cycles in a row.
- R3: When `vdly` is N greater than 0, horizontal counting begins at the Nth horizontal edge after a vertical edge. A horizontal edge acted on at the same clock edge as that vertical edge is not counted.
- R4: When `vdly` is 0, horizontal counting begins at the vertical edge itself.
- R5: Let the edge that begins horizontal counting be first seen high on the raw input at clock edge k. Then `start_pulse` is high for exactly the one cycle that follows clock edge k+3+`hdly`.
- R6: Horizontal edges that arrive while the horizontal delay is running have no effect, so a delay longer than a line places the start in a later line.
- R7: Vertical edges that arrive while a startup is pending (line delay or pixel delay running) are ignored, so a line delay longer than a frame places the start in a later frame.
- R8: At each horizontal edge, `line_period` takes the number of clock edges since the previous horizontal edge. It holds its value between horizontal edges.
- R9: If more than 65535 clocks pass between horizontal edges, the next reading of `line_period` is 65535 (0xFFFF).
- R10: At each vertical edge, the phase is the number of clocks since the last horizontal edge, minus one. The edge is mid-line when the phase differs from half the reference period by less than a quarter of it. The reference period is the measured period once two horizontal edges have been seen, and `ppl` before that. `interlace` becomes 1 when this edge's mid-line result differs from the previous vertical edge's, and 0 when it matches. It changes only at vertical edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_in | input | 1 | Asynchronous horizontal sync input |
| vs_in | input | 1 | Asynchronous vertical sync input |
| hdly | input | 13 | Clocks from the line-delay-completing edge to start |
| vdly | input | 11 | Horizontal edges to wait after a vertical edge |
| ppl | input | 13 | Nominal pixels per line, period reference before measurement |
| start_pulse | output | 1 | One-cycle timing generator restart |
| line_period | output | 16 | Measured clocks between horizontal edges |
| interlace | output | 1 | 1 for interlaced, 0 for progressive input |

## Verification
A sequencer stuck in a wrong state shows at the ports as a missing, extra or shifted start pulse. This appears within one programmed delay of the next vertical edge, and the exact clock index of every pulse is compared. A period counter that loses counts or wraps shows up in `line_period` at the next horizontal edge, after one line at most. A wrong mid-line decision or a lost previous-frame flag shows up in `interlace` after the next vertical edge.

// File: rtl/sync_start_pkg.sv
package sync_start_pkg;

    localparam int unsigned PERIOD_W = 16;
    localparam int unsigned DEF_HDLY = 61;
    localparam int unsigned DEF_VDLY = 3;

    typedef logic [PERIOD_W-1:0] period_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_VWAIT = 2'd1,
        SEQ_HWAIT = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic vs;
        logic hs;
    } sync_evt_t;

    function automatic period_t sat_inc(input period_t v);
        return (v == '1) ? v : v + period_t'(1);
    endfunction

    function automatic period_t abs_diff(input period_t a, input period_t b);
        return (a > b) ? a - b : b - a;
    endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [2:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q <= '0;
            end else begin
                sh_q <= {sh_q[1:0], d[i]};
            end
        end
        assign rise[i] = sh_q[1] & ~sh_q[2];
    end
endmodule

// File: rtl/line_period_meter.sv
module line_period_meter
    import sync_start_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hs_rise,
    output period_t period,
    output period_t phase,
    output logic    valid
);
    period_t    cnt_q;
    period_t    period_q;
    logic [1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            period_q <= '0;
            seen_q   <= '0;
        end else if (hs_rise) begin
            period_q <= sat_inc(cnt_q);
            cnt_q    <= '0;
            if (seen_q != 2'd2) begin
                seen_q <= seen_q + 2'd1;
            end
        end else begin
            cnt_q <= sat_inc(cnt_q);
        end
    end

    assign period = period_q;
    assign phase  = cnt_q;
    assign valid  = (seen_q == 2'd2);
endmodule

// File: rtl/start_sequencer.sv
module start_sequencer
    import sync_start_pkg::*;
#(
    parameter int unsigned HDLY_W = 13,
    parameter int unsigned VDLY_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_rise,
    input  logic              vs_rise,
    input  logic [HDLY_W-1:0] hdly,
    input  logic [VDLY_W-1:0] vdly,
    output logic              start,
    output seq_state_t        state
);
    seq_state_t        state_q;
    logic [VDLY_W-1:0] vleft_q;
    logic [HDLY_W-1:0] hleft_q;
    logic              start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            vleft_q <= '0;
            hleft_q <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (vs_rise) begin
                        if (vdly == '0) begin
                            state_q <= SEQ_HWAIT;
                            hleft_q <= hdly;
                        end else begin
                            state_q <= SEQ_VWAIT;
                            vleft_q <= vdly;
                        end
                    end
                end
                SEQ_VWAIT: begin
                    if (hs_rise) begin
                        if (vleft_q == VDLY_W'(1)) begin
                            state_q <= SEQ_HWAIT;
                            hleft_q <= hdly;
                        end else begin
                            vleft_q <= vleft_q - VDLY_W'(1);
                        end
                    end
                end
                SEQ_HWAIT: begin
                    if (hleft_q == '0) begin
                        start_q <= 1'b1;
                        state_q <= SEQ_IDLE;
                    end else begin
                        hleft_q <= hleft_q - HDLY_W'(1);
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign start = start_q;
    assign state = state_q;
endmodule

// File: rtl/interlace_detector.sv
module interlace_detector
    import sync_start_pkg::*;
#(
    parameter int unsigned PPL_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vs_rise,
    input  period_t          phase,
    input  period_t          period,
    input  logic             period_ok,
    input  logic [PPL_W-1:0] ppl,
    output logic             interlace
);
    period_t ref_per;
    period_t half_per;
    period_t quarter_per;
    logic    mid_now;
    logic    mid_prev_q;
    logic    ilace_q;

    always_comb begin
        ref_per     = period_ok ? period : period_t'(ppl);
        half_per    = ref_per >> 1;
        quarter_per = ref_per >> 2;
        mid_now     = abs_diff(phase, half_per) < quarter_per;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_prev_q <= 1'b0;
            ilace_q    <= 1'b0;
        end else if (vs_rise) begin
            mid_prev_q <= mid_now;
            ilace_q    <= mid_now ^ mid_prev_q;
        end
    end

    assign interlace = ilace_q;
endmodule

// File: rtl/sync_start_gen.sv
module sync_start_gen
    import sync_start_pkg::*;
#(
    parameter int unsigned HDLY_W = 13,
    parameter int unsigned VDLY_W = 11,
    parameter int unsigned PPL_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_in,
    input  logic              vs_in,
    input  logic [HDLY_W-1:0] hdly,
    input  logic [VDLY_W-1:0] vdly,
    input  logic [PPL_W-1:0]  ppl,
    output logic              start_pulse,
    output logic [15:0]       line_period,
    output logic              interlace
);
    sync_evt_t  evt;
    logic [1:0] rise_vec;
    logic       hs_rise;
    logic       vs_rise;
    period_t    period;
    period_t    phase;
    logic       period_ok;
    seq_state_t seq_state;

    sync_edge_det #(.N(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    ({vs_in, hs_in}),
        .rise (rise_vec)
    );

    assign evt     = sync_evt_t'(rise_vec);
    assign hs_rise = evt.hs;
    assign vs_rise = evt.vs;

    line_period_meter u_meter (
        .clk     (clk),
        .rst     (rst),
        .hs_rise (hs_rise),
        .period  (period),
        .phase   (phase),
        .valid   (period_ok)
    );

    start_sequencer #(.HDLY_W(HDLY_W), .VDLY_W(VDLY_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .hs_rise (hs_rise),
        .vs_rise (vs_rise),
        .hdly    (hdly),
        .vdly    (vdly),
        .start   (start_pulse),
        .state   (seq_state)
    );

    interlace_detector #(.PPL_W(PPL_W)) u_ilace (
        .clk       (clk),
        .rst       (rst),
        .vs_rise   (vs_rise),
        .phase     (phase),
        .period    (period),
        .period_ok (period_ok),
        .ppl       (ppl),
        .interlace (interlace)
    );

    assign line_period = period;
endmodule

// File: rtl/sync_start_gen_chk.sv
module sync_start_gen_chk
    import sync_start_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       hs_rise,
    input logic       vs_rise,
    input seq_state_t state,
    input logic       start,
    input period_t    line_period,
    input logic       interlace
);
    // R2: start is a single-cycle pulse
    p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    // R5: a start only follows a running horizontal delay
    p_start_after_hwait_r5: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(state) == SEQ_HWAIT);

    // R3: no start while idle or waiting for lines
    p_no_start_from_idle_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(state) != SEQ_HWAIT) |-> !start);

    // R8: readback holds without a horizontal edge
    p_period_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(hs_rise) |-> $stable(line_period));

    // R10: interlace flag moves only at vertical edges
    p_ilace_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(vs_rise) |-> $stable(interlace));

    // R7: a vertical edge while waiting for lines does not leave that wait
    p_vs_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_VWAIT && vs_rise && !hs_rise) |=> state == SEQ_VWAIT);
endmodule

bind sync_start_gen sync_start_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .hs_rise     (hs_rise),
    .vs_rise     (vs_rise),
    .state       (seq_state),
    .start       (start_pulse),
    .line_period (line_period),
    .interlace   (interlace)
);

// File: tb/sync_start_gen_test.sv
module sync_start_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_CLKS  = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs_in = 1'b0;
    logic        vs_in = 1'b0;
    logic [12:0] hdly = 13'd61;
    logic [10:0] vdly = 11'd3;
    logic [12:0] ppl  = 13'd100;
    logic        start_pulse;
    logic [15:0] line_period;
    logic        interlace;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int exp_q[$];
    bit finished = 0;

    sync_start_gen uut (
        .clk         (clk),
        .rst         (rst),
        .hs_in       (hs_in),
        .vs_in       (vs_in),
        .hdly        (hdly),
        .vdly        (vdly),
        .ppl         (ppl),
        .start_pulse (start_pulse),
        .line_period (line_period),
        .interlace   (interlace)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model of start timing, in raw clock-edge indices (R3..R7)
    int  m_state = 0;
    int  m_vleft = 0;
    int  m_fire = 0;
    bit  hs_prev = 0;
    bit  vs_prev = 0;
    always @(posedge clk) begin
        bit hr;
        bit vr;
        cyc = cyc + 1;
        if (rst) begin
            m_state = 0;
        end else begin
            hr = hs_in && !hs_prev;
            vr = vs_in && !vs_prev;
            if (m_state == 2 && cyc >= m_fire - 1) m_state = 0;
            if (m_state == 0 && vr) begin
                if (vdly == 0) begin
                    m_fire = cyc + 3 + int'(hdly);
                    exp_q.push_back(m_fire);
                    m_state = 2;
                end else begin
                    m_vleft = int'(vdly);
                    m_state = 1;
                end
            end else if (m_state == 1 && hr) begin
                if (m_vleft == 1) begin
                    m_fire = cyc + 3 + int'(hdly);
                    exp_q.push_back(m_fire);
                    m_state = 2;
                end else begin
                    m_vleft = m_vleft - 1;
                end
            end
        end
        hs_prev = hs_in;
        vs_prev = vs_in;
    end

    // Monitor: pops expected start indices (R2, R5)
    always @(negedge clk) begin
        if (!rst && start_pulse) begin
            if (exp_q.size() == 0) begin
                check(0, "R5 unexpected start", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(cyc == e, "R5 start cycle", cyc, e);
            end
        end
    end

    task automatic line(input int vs_at);
        for (int i = 0; i < LINE_CLKS; i++) begin
            @(negedge clk);
            hs_in = (i < 4);
            if (i == vs_at) vs_in = 1'b1;
            if (i == vs_at + 5) vs_in = 1'b0;
        end
    endtask

    task automatic frame(input int nlines, input int vs_at);
        line(vs_at);
        for (int i = 1; i < nlines; i++) line(-1);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (160000) @(posedge clk);
        check(0, "watchdog expired", cyc, 0);
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        check(start_pulse == 0, "R1 start in reset", start_pulse, 0);
        check(line_period == 0, "R1 period in reset", line_period, 0);
        check(interlace == 0, "R1 interlace in reset", interlace, 0);
        rst = 1'b0;
        @(negedge clk);
        check(line_period == 0, "R1 period after reset", line_period, 0);

        // R3, R5: default delays, progressive frames
        hdly = 13'd61; vdly = 11'd3;
        for (int f = 0; f < 3; f++) frame(8, 1);
        check(line_period == 16'd100, "R8 line period", line_period, 100);
        check(interlace == 0, "R10 progressive", interlace, 0);

        // R10: alternating vertical phase means interlaced
        frame(4, 50);
        frame(4, 1);
        frame(4, 50);
        check(interlace == 1, "R10 interlaced", interlace, 1);
        frame(4, 50);
        check(interlace == 0, "R10 back to progressive", interlace, 0);

        // R6: horizontal delay longer than a line
        hdly = 13'd250; vdly = 11'd1;
        frame(8, 1);
        frame(8, 1);

        // R4: zero line delay starts from the vertical edge
        hdly = 13'd10; vdly = 11'd0;
        frame(4, 20);
        frame(4, 20);

        // R7: line delay longer than a frame, vertical edges while pending ignored
        hdly = 13'd5; vdly = 11'd10;
        for (int f = 0; f < 6; f++) frame(4, 1);
        check(exp_q.size() == 0, "R7 all starts seen", exp_q.size(), 0);

        // R8, R9: long gap without horizontal edges
        check(line_period == 16'd100, "R8 period before gap", line_period, 100);
        repeat (35000) @(negedge clk);
        check(line_period == 16'd100, "R8 period held in gap", line_period, 100);
        repeat (35000) @(negedge clk);
        line(-1);
        check(line_period == 16'hFFFF, "R9 saturated period", line_period, 65535);
        line(-1);
        check(line_period == 16'd100, "R8 period recovers", line_period, 100);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R5 no missing start", exp_q.size(), 0);
        report();
    end
endmodule